// File: doc/BRIEF.md
# Branch target unit

This block forms the next program counter value when a small microcontroller executes a branch. The program counter is 14 bits wide. A branch request carries a kind code, the address of the instruction that follows the branch (the base), an immediate operand and the two 8-bit register pairs DE and XA. From these the block builds one of five kinds of target. The absolute kind replaces the whole counter. The block kind keeps the top two bits of the base and takes a 12-bit field. The two register-indirect kinds keep the top six bits of the base and take DE or XA as the low byte. The short relative kind adds a signed 5-bit displacement to the base, and the sum wraps at 14 bits.

Requests come in over a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The block then drops `req_ready` while the branch executes, so a waiting request stays on the inputs until the block can take it. The requester must hold its fields steady while `req_valid` is high and `req_ready` is low. `req_ready` goes high again in the final execution cycle, so the next request can be taken on the same edge that ends the current one.

In that final cycle the registered target appears on `pc_next` and `pc_load` pulses for one cycle. The length and cycle count of the instruction on `req_kind` are decoded without a register, so the sequencer can read them before it issues the request.

Top module: `branch_target_unit`

## Requirements
- R1: During and right after reset, `req_ready` is 1, `pc_load` is 0 and `pc_next` is 0.
- R2: Kind 0 (absolute) loads `req_imm[13:0]`. `pc_load` rises in the 3rd cycle after the handshake edge.
- R3: Kind 2 (block) loads `{req_pc[13:12], req_imm[11:0]}`. `pc_load` rises in the 2nd cycle after the handshake edge.
- R4: Kind 3 (DE-indirect) loads `{req_pc[13:8], req_de}`. `pc_load` rises in the 3rd cycle after the handshake edge.
- R5: Kind 4 (XA-indirect) loads `{req_pc[13:8], req_xa}`. `pc_load` rises in the 3rd cycle after the handshake edge.
- R6: Kind 1 (relative) loads `req_pc` plus the sign-extended `req_imm[4:0]`, modulo 2^14. Bits `req_imm[13:5]` have no effect. `pc_load` rises in the 2nd cycle after the handshake edge.
- R7: `instr_len`/`instr_cycles` decode `req_kind` without delay: absolute 3/3, relative 1/2, block 2/2, DE 2/3, XA 2/3, and kinds 5 to 7 give 0/1.
- R8: `req_ready` is 0 in every execution cycle except the last. Input values presented after the handshake edge do not change the target.
- R9: `pc_load` is high for exactly one cycle per branch, and never while `req_ready` is 0. A request with kind 5 to 7 is consumed in one cycle, produces no strobe and leaves `pc_next` unchanged.
- R10: A request presented in the final execution cycle is taken on the edge that ends it, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Branch request present |
| req_ready | output | 1 | Block can take a request on this edge |
| req_kind | input | 3 | Branch kind code (see R2 to R7) |
| req_pc | input | 14 | Address of the instruction after the branch |
| req_imm | input | 14 | Immediate operand field |
| req_de | input | 8 | DE register pair |
| req_xa | input | 8 | XA register pair |
| pc_next | output | 14 | Registered branch target |
| pc_load | output | 1 | One-cycle strobe to load `pc_next` into the PC |
| instr_len | output | 2 | Byte length of the kind on `req_kind` |
| instr_cycles | output | 2 | Execution cycles of the kind on `req_kind` |

## Verification
A corrupted cycle counter shows up at the ports within one branch. The strobe comes a cycle early or late, or `req_ready` is released while `pc_load` is still low, and the bench checks both signals in every execution cycle. A wrong base field or a wrong sign extension shows up as a bad `pc_next` in the very cycle the strobe appears. A stale register that captured inputs after the handshake shows up the same way, because the bench scrambles every input as soon as a request is taken. Wrap-around cases at both ends of the 14-bit space are driven on purpose.

// File: rtl/btu_pkg.sv
package btu_pkg;

  typedef enum logic [2:0] {
    BK_ABS   = 3'd0,
    BK_REL   = 3'd1,
    BK_BLOCK = 3'd2,
    BK_DE    = 3'd3,
    BK_XA    = 3'd4
  } br_kind_e;

  // timing and size facts for one branch kind
  typedef struct packed {
    logic [1:0] len;
    logic [1:0] cyc;
    logic       loads;
  } br_info_t;

endpackage

// File: rtl/btu_decode.sv
module btu_decode
  import btu_pkg::*;
(
  input  logic [2:0] kind,
  output br_info_t   info
);

  always_comb begin
    case (kind)
      BK_ABS:   info = '{len: 2'd3, cyc: 2'd3, loads: 1'b1};
      BK_REL:   info = '{len: 2'd1, cyc: 2'd2, loads: 1'b1};
      BK_BLOCK: info = '{len: 2'd2, cyc: 2'd2, loads: 1'b1};
      BK_DE:    info = '{len: 2'd2, cyc: 2'd3, loads: 1'b1};
      BK_XA:    info = '{len: 2'd2, cyc: 2'd3, loads: 1'b1};
      default:  info = '{len: 2'd0, cyc: 2'd1, loads: 1'b0};
    endcase
  end

endmodule

// File: rtl/btu_target.sv
module btu_target
  import btu_pkg::*;
#(
  parameter int PC_W   = 14,
  parameter int BLK_W  = 12,
  parameter int REG_W  = 8,
  parameter int DISP_W = 5
) (
  input  logic [2:0]      kind,
  input  logic [PC_W-1:0] base_pc,
  input  logic [PC_W-1:0] imm,
  input  logic [REG_W-1:0] de,
  input  logic [REG_W-1:0] xa,
  output logic [PC_W-1:0] target
);

  localparam int KEEP_BLK = PC_W - BLK_W;
  localparam int KEEP_REG = PC_W - REG_W;

  logic [PC_W-1:0] disp_ext;
  logic [PC_W-1:0] blk_tgt;
  logic [PC_W-1:0] de_tgt;
  logic [PC_W-1:0] xa_tgt;

  generate
    if (DISP_W >= PC_W) begin : g_disp_full
      assign disp_ext = imm;
    end else begin : g_disp_ext
      assign disp_ext = {{(PC_W-DISP_W){imm[DISP_W-1]}}, imm[DISP_W-1:0]};
    end
  endgenerate

  assign blk_tgt = {base_pc[PC_W-1 -: KEEP_BLK], imm[BLK_W-1:0]};
  assign de_tgt  = {base_pc[PC_W-1 -: KEEP_REG], de};
  assign xa_tgt  = {base_pc[PC_W-1 -: KEEP_REG], xa};

  always_comb begin
    case (kind)
      BK_ABS:   target = imm;
      BK_REL:   target = base_pc + disp_ext;
      BK_BLOCK: target = blk_tgt;
      BK_DE:    target = de_tgt;
      BK_XA:    target = xa_tgt;
      default:  target = base_pc;
    endcase
  end

endmodule

// File: rtl/btu_seq.sv
module btu_seq
  import btu_pkg::*;
#(
  parameter int PC_W = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  br_info_t        info,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] pc_next,
  output logic            pc_load
);

  logic       busy;
  logic [1:0] cnt;
  logic       load_en;
  logic [PC_W-1:0] pc_q;
  logic       last_cyc;
  logic       fire;

  assign last_cyc  = busy && (cnt == 2'd0);
  assign req_ready = !busy || last_cyc;
  assign fire      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= 2'd0;
      load_en <= 1'b0;
      pc_q    <= '0;
    end else if (fire) begin
      busy    <= 1'b1;
      cnt     <= info.cyc - 2'd1;
      load_en <= info.loads;
      if (info.loads) pc_q <= target;
    end else if (busy) begin
      if (cnt != 2'd0) begin
        cnt <= cnt - 2'd1;
      end else begin
        busy    <= 1'b0;
        load_en <= 1'b0;
      end
    end
  end

  assign pc_next = pc_q;
  assign pc_load = last_cyc && load_en;

endmodule

// File: rtl/branch_target_unit.sv
module branch_target_unit
  import btu_pkg::*;
#(
  parameter int PC_W   = 14,
  parameter int BLK_W  = 12,
  parameter int REG_W  = 8,
  parameter int DISP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_kind,
  input  logic [PC_W-1:0]  req_pc,
  input  logic [PC_W-1:0]  req_imm,
  input  logic [REG_W-1:0] req_de,
  input  logic [REG_W-1:0] req_xa,
  output logic [PC_W-1:0]  pc_next,
  output logic             pc_load,
  output logic [1:0]       instr_len,
  output logic [1:0]       instr_cycles
);

  br_info_t        info;
  logic [PC_W-1:0] target;

  btu_decode u_decode (
    .kind (req_kind),
    .info (info)
  );

  btu_target #(
    .PC_W   (PC_W),
    .BLK_W  (BLK_W),
    .REG_W  (REG_W),
    .DISP_W (DISP_W)
  ) u_target (
    .kind    (req_kind),
    .base_pc (req_pc),
    .imm     (req_imm),
    .de      (req_de),
    .xa      (req_xa),
    .target  (target)
  );

  btu_seq #(
    .PC_W (PC_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .info      (info),
    .target    (target),
    .pc_next   (pc_next),
    .pc_load   (pc_load)
  );

  assign instr_len    = info.len;
  assign instr_cycles = info.cyc;

endmodule

// File: rtl/branch_target_unit_chk.sv
module branch_target_unit_chk #(
  parameter int PC_W   = 14,
  parameter int BLK_W  = 12,
  parameter int REG_W  = 8,
  parameter int DISP_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [2:0]       req_kind,
  input logic [PC_W-1:0]  req_pc,
  input logic [PC_W-1:0]  req_imm,
  input logic [REG_W-1:0] req_de,
  input logic [REG_W-1:0] req_xa,
  input logic [PC_W-1:0]  pc_next,
  input logic             pc_load,
  input logic [1:0]       instr_len,
  input logic [1:0]       instr_cycles
);

  logic            hs;
  logic [PC_W-1:0] rel_exp;

  assign hs      = req_valid && req_ready;
  assign rel_exp = req_pc + {{(PC_W-DISP_W){req_imm[DISP_W-1]}}, req_imm[DISP_W-1:0]};

  a_r2_abs_target: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && req_kind == 3'd0) |-> ##3 (pc_load && pc_next == $past(req_imm, 3)));

  a_r3_block_target: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && req_kind == 3'd2) |-> ##2 (pc_load &&
      pc_next[PC_W-1:BLK_W] == $past(req_pc[PC_W-1:BLK_W], 2) &&
      pc_next[BLK_W-1:0] == $past(req_imm[BLK_W-1:0], 2)));

  a_r4_de_target: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && req_kind == 3'd3) |-> ##3 (pc_load &&
      pc_next == {$past(req_pc[PC_W-1:REG_W], 3), $past(req_de, 3)}));

  a_r5_xa_target: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && req_kind == 3'd4) |-> ##3 (pc_load &&
      pc_next == {$past(req_pc[PC_W-1:REG_W], 3), $past(req_xa, 3)}));

  a_r6_rel_target: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && req_kind == 3'd1) |-> ##2 (pc_load && pc_next == $past(rel_exp, 2)));

  a_r7_abs_info: assert property (@(posedge clk) disable iff (!rst_n)
    (req_kind == 3'd0) |-> (instr_len == 2'd3 && instr_cycles == 2'd3));

  a_r9_no_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> !pc_load);

  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !pc_load);

  a_r9_unknown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && req_kind > 3'd4) |=> (!pc_load && req_ready && $stable(pc_next)));

endmodule

bind branch_target_unit branch_target_unit_chk u_chk (.*);

// File: tb/branch_target_unit_test.sv
`timescale 1ns/1ps
module branch_target_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [2:0]  req_kind;
  logic [13:0] req_pc;
  logic [13:0] req_imm;
  logic [7:0]  req_de;
  logic [7:0]  req_xa;
  logic [13:0] pc_next;
  logic        pc_load;
  logic [1:0]  instr_len;
  logic [1:0]  instr_cycles;

  always #10 clk = ~clk;

  branch_target_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_pc(req_pc), .req_imm(req_imm), .req_de(req_de),
    .req_xa(req_xa), .pc_next(pc_next), .pc_load(pc_load),
    .instr_len(instr_len), .instr_cycles(instr_cycles)
  );

  int checks = 0;
  int errors = 0;
  logic [13:0] last_pc = 14'd0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_len(logic [2:0] k);
    case (k)
      3'd0: return 3;
      3'd1: return 1;
      3'd2, 3'd3, 3'd4: return 2;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_cyc(logic [2:0] k);
    case (k)
      3'd0, 3'd3, 3'd4: return 3;
      3'd1, 3'd2: return 2;
      default: return 1;
    endcase
  endfunction

  function automatic string tag(logic [2:0] k);
    case (k)
      3'd0: return "R2";
      3'd1: return "R6";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [13:0] exp_target(logic [2:0] k, logic [13:0] pc,
      logic [13:0] imm, logic [7:0] de, logic [7:0] xa);
    logic [13:0] d;
    d = {{9{imm[4]}}, imm[4:0]};
    case (k)
      3'd0: return imm;
      3'd1: return pc + d;
      3'd2: return {pc[13:12], imm[11:0]};
      3'd3: return {pc[13:8], de};
      3'd4: return {pc[13:8], xa};
      default: return last_pc;
    endcase
  endfunction

  task automatic drive(logic [2:0] k, logic [13:0] pc, logic [13:0] imm,
      logic [7:0] de, logic [7:0] xa);
    req_valid = 1'b1;
    req_kind  = k;
    req_pc    = pc;
    req_imm   = imm;
    req_de    = de;
    req_xa    = xa;
    #1;
    chk(instr_len == 2'(exp_len(k)), "R7", "instr_len", instr_len, exp_len(k));
    chk(instr_cycles == 2'(exp_cyc(k)), "R7", "instr_cycles", instr_cycles, exp_cyc(k));
    chk(req_ready == 1'b1, "R10", "ready before handshake", req_ready, 1);
  endtask

  // the request on the inputs is taken at the next rising edge
  task automatic expect_run(logic [2:0] k, logic [13:0] tgt);
    int c;
    bit ld;
    c  = exp_cyc(k);
    ld = (k <= 3'd4);
    @(negedge clk);
    // scramble inputs: they must not affect the branch in flight (R8)
    req_valid = 1'b0;
    req_kind  = 3'($urandom);
    req_pc    = 14'($urandom);
    req_imm   = 14'($urandom);
    req_de    = 8'($urandom);
    req_xa    = 8'($urandom);
    for (int i = 1; i <= c; i++) begin
      if (i < c) begin
        chk(req_ready == 1'b0, "R8", "ready while executing", req_ready, 0);
        chk(pc_load == 1'b0, "R9", "early strobe", pc_load, 0);
        @(negedge clk);
      end else begin
        chk(req_ready == 1'b1, "R8", "ready in final cycle", req_ready, 1);
        if (ld) begin
          chk(pc_load == 1'b1, tag(k), "strobe in final cycle", pc_load, 1);
          chk(pc_next == tgt, tag(k), "target", pc_next, tgt);
          last_pc = tgt;
        end else begin
          chk(pc_load == 1'b0, "R9", "strobe for unknown kind", pc_load, 0);
          chk(pc_next == last_pc, "R9", "pc kept on unknown kind", pc_next, last_pc);
        end
      end
    end
  endtask

  task automatic issue(logic [2:0] k, logic [13:0] pc, logic [13:0] imm,
      logic [7:0] de, logic [7:0] xa);
    logic [13:0] t;
    @(negedge clk);
    chk(pc_load == 1'b0, "R9", "strobe width", pc_load, 0);
    t = exp_target(k, pc, imm, de, xa);
    drive(k, pc, imm, de, xa);
    expect_run(k, t);
  endtask

  // present a new request in the final cycle of the current one (R10)
  task automatic chain(logic [2:0] k, logic [13:0] pc, logic [13:0] imm,
      logic [7:0] de, logic [7:0] xa);
    logic [13:0] t;
    t = exp_target(k, pc, imm, de, xa);
    drive(k, pc, imm, de, xa);
    expect_run(k, t);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 3'd0;
    req_pc = '0; req_imm = '0; req_de = '0; req_xa = '0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
    chk(pc_load == 1'b0, "R1", "strobe in reset", pc_load, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(pc_load == 1'b0, "R1", "strobe after reset", pc_load, 0);
    chk(pc_next == 14'd0, "R1", "pc after reset", pc_next, 0);

    // directed corners
    issue(3'd0, 14'h0123, 14'h3ABC, 8'h11, 8'h22);       // R2 absolute
    issue(3'd2, 14'h3F00, 14'h2456, 8'h00, 8'h00);       // R3 keeps 13..12
    issue(3'd3, 14'h2A77, 14'h0000, 8'hC5, 8'h3C);       // R4 DE low byte
    issue(3'd4, 14'h15FF, 14'h0000, 8'hC5, 8'h3C);       // R5 XA low byte
    issue(3'd1, 14'h0002, 14'h001B, 8'h00, 8'h00);       // R6 -5 wraps low
    issue(3'd1, 14'h3FFF, 14'h000F, 8'h00, 8'h00);       // R6 +15 wraps high
    issue(3'd1, 14'h1000, 14'h3FF0, 8'h00, 8'h00);       // R6 -16, high imm ignored
    issue(3'd5, 14'h1234, 14'h0567, 8'h89, 8'hAB);       // R9 unknown kind
    issue(3'd7, 14'h3333, 14'h3333, 8'h33, 8'h33);       // R9 unknown kind
    issue(3'd2, 14'h1F00, 14'h0ABC, 8'h00, 8'h00);       // R10 chain head
    chain(3'd3, 14'h0F00, 14'h0000, 8'h5A, 8'h00);       // R10 chained DE
    chain(3'd4, 14'h3E00, 14'h0000, 8'h00, 8'hA5);       // R10 chained XA
    chain(3'd6, 14'h0000, 14'h0000, 8'h00, 8'h00);       // R10 chained unknown
    chain(3'd0, 14'h0000, 14'h0001, 8'h00, 8'h00);       // R10 chained absolute

    // constrained random mix, half the time chained
    for (int n = 0; n < 400; n++) begin
      logic [2:0] k;
      k = ($urandom % 10 == 0) ? 3'(5 + $urandom % 3) : 3'($urandom % 5);
      if ($urandom % 2)
        chain(k, 14'($urandom), 14'($urandom), 8'($urandom), 8'($urandom));
      else
        issue(k, 14'($urandom), 14'($urandom), 8'($urandom), 8'($urandom));
    end

    @(negedge clk);
    chk(pc_load == 1'b0, "R9", "strobe width at end", pc_load, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule